// File: doc/BRIEF.md
# Passive Membrane Euler Integrator

This block holds the state of one passive neuron compartment and moves it forward by one fixed 0.1 ms timestep each time it is strobed. The state is the membrane voltage plus two synaptic state variables. All of it is stored as signed fixed-point integers, and each step is a single forward-Euler update. Four currents contribute to the update:

- a leak current toward a -64 mV resting level;
- an injected current that is on only inside a time window;
- an excitatory synaptic current, driven by the difference of two decaying states that every input event bumps;
- a gap-junction current shared with one coupled neighbour.

Every current is pre-multiplied by dt/C, where C is 10 pF. The datapath therefore adds voltage increments in microvolts directly.

A scheduler pulses `stepIn` once per simulated timestep and presents the simulation time in microseconds. It also feeds in the neighbour's voltage. The neighbour's own integrator takes `gapOut`, which is the equal-and-opposite coupling increment.

Top module: `passive_membrane_integrator`

## Requirements
- R1: During and right after reset, `vMem` is -64000 (units of 1 µV), both synaptic states are zero and `validOut` is 0.
- R2: `vMem` changes only at the clock edge where `stepIn` is high. `validOut` is high in exactly the cycle after each such edge.
- R3: The leak increment per step is (1311 × (-64000 − V)) >>> 16. This is 2 nS × dt/C in Q16.
- R4: The injection increment is +300 µV when 50000 < simTimeUs < 100000, both bounds strict. It is 0 otherwise, including at exactly 50000 and exactly 100000.
- R5: The synaptic increment is computed in two stages. First, m = sat32(((B − A) × (−V)) >>> 16). Then the increment is (197 × m) >>> 16. A and B are Q16 values, so 1.0 is 65536.
- R6: On a step, A ← A − ((4369 × A) >>> 16), a 1.5 ms time constant. Likewise B ← B − ((1311 × B) >>> 16), a 5 ms time constant.
- R7: An event adds 65536 to both A and B. Without a step it is added at once. On a step cycle it is added after the decay. All increments within a step use the pre-step V, A and B.
- R8: The gap increment is G = (655 × (vNeighbour − V)) >>> 16, which models 1 nS. `gapOut` shows −G combinationally from the present V and vNeighbour.
- R9: The new voltage is sat32(V + leak + injection + synaptic + G). A and B saturate to the 24-bit signed range (max 8388607) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stepIn | input | 1 | Advance one timestep at this edge |
| eventIn | input | 1 | Excitatory synaptic event |
| simTimeUs | input | 32 | Simulation time in µs, unsigned |
| vNeighbour | input | 32 | Coupled neighbour voltage, signed µV |
| vMem | output | 32 | Membrane voltage, signed µV |
| gapOut | output | 32 | Gap increment for the neighbour, signed µV |
| validOut | output | 1 | High the cycle after an update |

## Verification
A step or event that is presented during a cycle updates `vMem` and the hidden synaptic state at the next rising edge. `validOut` rises at that same edge, so both are due one cycle after the stimulus. The bench drives inputs on the falling edge and compares `vMem` and `validOut` on the following falling edge. `gapOut` is combinational, so it is compared shortly after the inputs settle in the same cycle, before the edge that could move V.

// File: rtl/membrane_pkg.sv
package membrane_pkg;
  typedef struct packed {
    logic commit;
    logic addEvent;
    logic injOn;
  } stepCtrl_t;
endpackage

// File: rtl/membrane_control.sv
module membrane_control
  import membrane_pkg::*;
#(
  parameter int TW     = 32,
  parameter int INJ_LO = 50000,
  parameter int INJ_HI = 100000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stepIn,
  input  logic          eventIn,
  input  logic [TW-1:0] simTimeUs,
  output stepCtrl_t     ctrl,
  output logic          validOut
);
  localparam logic [TW-1:0] LO = TW'(INJ_LO);
  localparam logic [TW-1:0] HI = TW'(INJ_HI);

  always_comb begin
    ctrl.commit   = stepIn;
    ctrl.addEvent = eventIn;
    ctrl.injOn    = (simTimeUs > LO) && (simTimeUs < HI);
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= stepIn;
  end
endmodule

// File: rtl/membrane_datapath.sv
module membrane_datapath
  import membrane_pkg::*;
#(
  parameter int VW       = 32,
  parameter int SW       = 24,
  parameter int FRAC     = 16,
  parameter int E_REST   = -64000,
  parameter int LEAK_K   = 1311,
  parameter int INJ_STEP = 300,
  parameter int SYN_K    = 197,
  parameter int GAP_K    = 655,
  parameter int DECAY_A  = 4369,
  parameter int DECAY_B  = 1311
) (
  input  logic                 clk,
  input  logic                 rst,
  input  stepCtrl_t            ctrl,
  input  logic signed [VW-1:0] vNeighbour,
  output logic signed [VW-1:0] vMem,
  output logic signed [VW-1:0] gapOut
);
  localparam logic signed [63:0] ONE = 64'sd1 <<< FRAC;

  function automatic logic signed [63:0] satTo(input logic signed [63:0] x, input int w);
    logic signed [63:0] maxV, minV;
    maxV = (64'sd1 <<< (w - 1)) - 64'sd1;
    minV = -maxV - 64'sd1;
    if (x > maxV)      return maxV;
    else if (x < minV) return minV;
    else               return x;
  endfunction

  logic signed [SW-1:0] synA, synB;
  logic signed [63:0] vExt, aExt, bExt, nExt;
  logic signed [63:0] leakTerm, injTerm, synProd, synMid, synTerm, gapTerm, vSum;
  logic signed [63:0] aNext, bNext;

  always_comb begin
    vExt = 64'(vMem);
    aExt = 64'(synA);
    bExt = 64'(synB);
    nExt = 64'(vNeighbour);
    leakTerm = (64'(LEAK_K) * (64'(E_REST) - vExt)) >>> FRAC;
    injTerm  = ctrl.injOn ? 64'(INJ_STEP) : 64'sd0;
    synProd  = ((bExt - aExt) * (-vExt)) >>> FRAC;
    synMid   = satTo(synProd, VW);
    synTerm  = (64'(SYN_K) * synMid) >>> FRAC;
    gapTerm  = (64'(GAP_K) * (nExt - vExt)) >>> FRAC;
    vSum     = vExt + leakTerm + injTerm + synTerm + gapTerm;
    aNext = aExt;
    bNext = bExt;
    if (ctrl.commit) begin
      aNext = aExt - ((64'(DECAY_A) * aExt) >>> FRAC);
      bNext = bExt - ((64'(DECAY_B) * bExt) >>> FRAC);
    end
    if (ctrl.addEvent) begin
      aNext = aNext + ONE;
      bNext = bNext + ONE;
    end
    aNext = satTo(aNext, SW);
    bNext = satTo(bNext, SW);
    gapOut = VW'(satTo(-gapTerm, VW));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vMem <= VW'(E_REST);
      synA <= '0;
      synB <= '0;
    end else begin
      if (ctrl.commit) vMem <= VW'(satTo(vSum, VW));
      synA <= SW'(aNext);
      synB <= SW'(bNext);
    end
  end
endmodule

// File: rtl/passive_membrane_integrator.sv
module passive_membrane_integrator
  import membrane_pkg::*;
#(
  parameter int VW = 32,
  parameter int SW = 24,
  parameter int TW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stepIn,
  input  logic                 eventIn,
  input  logic [TW-1:0]        simTimeUs,
  input  logic signed [VW-1:0] vNeighbour,
  output logic signed [VW-1:0] vMem,
  output logic signed [VW-1:0] gapOut,
  output logic                 validOut
);
  stepCtrl_t ctrl;

  membrane_control #(.TW(TW)) u_ctrl (
    .clk(clk), .rst(rst), .stepIn(stepIn), .eventIn(eventIn),
    .simTimeUs(simTimeUs), .ctrl(ctrl), .validOut(validOut)
  );

  membrane_datapath #(.VW(VW), .SW(SW)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .vNeighbour(vNeighbour),
    .vMem(vMem), .gapOut(gapOut)
  );
endmodule

// File: rtl/membrane_checker.sv
module membrane_checker #(
  parameter int VW = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 stepIn,
  input logic signed [VW-1:0] vNeighbour,
  input logic signed [VW-1:0] vMem,
  input logic signed [VW-1:0] gapOut,
  input logic                 validOut
);
  // R2: voltage holds without a step
  a_r2_hold_voltage: assert property (@(posedge clk) disable iff (rst)
    !stepIn |=> $stable(vMem));
  // R2: valid follows a step by one cycle
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    stepIn |=> validOut);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !stepIn |=> !validOut);
  // R8: no coupling increment when voltages match
  a_r8_gap_zero: assert property (@(posedge clk) disable iff (rst)
    (vNeighbour == vMem) |-> (gapOut == '0));
  // R8: a higher neighbour means this cell gains, so the neighbour's share is not positive
  a_r8_gap_sign: assert property (@(posedge clk) disable iff (rst)
    (vNeighbour > vMem) |-> (gapOut <= 0));
endmodule

bind passive_membrane_integrator membrane_checker #(.VW(VW)) u_chk (
  .clk(clk), .rst(rst), .stepIn(stepIn), .vNeighbour(vNeighbour),
  .vMem(vMem), .gapOut(gapOut), .validOut(validOut)
);

// File: tb/tb_passive_membrane_integrator.sv
module tb_passive_membrane_integrator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stepIn = 1'b0, eventIn = 1'b0;
  logic [31:0] simTimeUs = '0;
  logic signed [31:0] vNeighbour = -32'sd64000;
  logic signed [31:0] vMem, gapOut;
  logic validOut;

  int checks = 0, fails = 0;
  longint mV = -64000, mA = 0, mB = 0;

  always #2 clk = ~clk;

  passive_membrane_integrator dut (
    .clk(clk), .rst(rst), .stepIn(stepIn), .eventIn(eventIn),
    .simTimeUs(simTimeUs), .vNeighbour(vNeighbour),
    .vMem(vMem), .gapOut(gapOut), .validOut(validOut)
  );

  function automatic longint clampW(longint x, int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    if (x > hi) return hi;
    if (x < -hi - 1) return -hi - 1;
    return x;
  endfunction

  function automatic longint expGap(longint v, longint n);
    return clampW(-((655 * (n - v)) >>> 16), 32);
  endfunction

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic cycle(string tag, bit st, bit ev, int t, int vn);
    longint leak, inj, mid, syn, gap, na, nb;
    @(negedge clk);
    stepIn = st; eventIn = ev; simTimeUs = t; vNeighbour = vn;
    #1;
    check({tag, " gapOut"}, longint'(gapOut), expGap(mV, vn));
    if (st) begin
      leak = (1311 * (-64000 - mV)) >>> 16;
      inj  = (t > 50000 && t < 100000) ? 300 : 0;
      mid  = clampW(((mB - mA) * (-mV)) >>> 16, 32);
      syn  = (197 * mid) >>> 16;
      gap  = (655 * (longint'(vn) - mV)) >>> 16;
      na = mA - ((4369 * mA) >>> 16);
      nb = mB - ((1311 * mB) >>> 16);
      mV = clampW(mV + leak + inj + syn + gap, 32);
    end else begin
      na = mA; nb = mB;
    end
    if (ev) begin na += 65536; nb += 65536; end
    mA = clampW(na, 24);
    mB = clampW(nb, 24);
    @(negedge clk);
    stepIn = 1'b0; eventIn = 1'b0;
    #1;
    check({tag, " vMem"}, longint'(vMem), mV);
    check({tag, " validOut"}, longint'(validOut), longint'(st));
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    int seed = 12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 vMem", longint'(vMem), -64000);
    check("R1 validOut", longint'(validOut), 0);
    // at rest nothing moves
    repeat (3) cycle("R3 rest", 1, 0, 0, -64000);
    // injection inside the window, then at both boundaries
    cycle("R4 inside", 1, 0, 60000, -64000);
    cycle("R4 lowEdge", 1, 0, 50000, -64000);
    cycle("R4 highEdge", 1, 0, 100000, -64000);
    cycle("R4 inside2", 1, 0, 99999, -64000);
    repeat (5) cycle("R3 relax", 1, 0, 0, -64000);
    // event without a step leaves V alone
    cycle("R7 eventOnly", 0, 1, 0, -64000);
    repeat (10) cycle("R5 R6 synapse", 1, 0, 0, -64000);
    // event together with a step
    cycle("R7 eventStep", 1, 1, 0, -64000);
    repeat (10) cycle("R7 after", 1, 0, 0, -64000);
    // gap coupling in both directions
    repeat (4) cycle("R8 up", 1, 0, 0, 0);
    repeat (4) cycle("R8 down", 1, 0, 0, -100000);
    cycle("R8 extreme", 0, 0, 0, 32'sh7fffffff);
    // pile of events to saturate the synaptic state
    repeat (200) cycle("R9 satEvents", 0, 1, 0, -64000);
    repeat (20) cycle("R9 satSteps", 1, 0, 0, 32'sh7fffffff);
    repeat (30) cycle("R9 satSteps2", 1, 0, 0, -32'sh7fffffff);
    // reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; mV = -64000; mA = 0; mB = 0;
    #1;
    check("R1 re-reset vMem", longint'(vMem), -64000);
    for (int i = 0; i < 3000; i++) begin
      bit st = ($urandom % 2) == 0;
      bit ev = ($urandom % 10) == 0;
      int t  = int'($urandom % 150000);
      int vn = -100000 + int'($urandom % 150000);
      if (i % 500 == 7) t = 50000;
      if (i % 500 == 9) t = 100000;
      cycle("R9 random", st, ev, t, vn);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule